// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Tick Generator

This block makes the timing pulses for a serial transmitter and receiver from the system clock. A write-only configuration register holds a two-bit prescale select and a three-bit rate select. The system clock first passes through a fixed divide-by-4 that produces a base-clock enable. The base clock is then divided by a prescale ratio from the non-binary set {1, 3, 4, 13}, then by 2 raised to the rate select. That gives the 16x oversample tick. A further divide by 16 gives the per-bit tick.

Each tick is a one-system-cycle pulse. The block also reports the current per-bit divisor in base-clock cycles, so that status logic can show it. Writing the register restarts every counter, so the new rate starts from a clean phase.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the configuration is zero (prescale 1, rate 0) and `bit_div` reads 16. The first `os_tick` comes on the 3rd clock edge after reset is released and repeats every 4 cycles. The first `bit_tick` comes on the 63rd edge.
- R2: Prescale select values 0, 1, 2 and 3 give divide ratios of 1, 3, 4 and 13, in that order. Any encoding outside these falls back to 13.
- R3: `bit_div` equals ratio × 16 × 2^rate, and is valid in the cycle after the write edge.
- R4: While no write occurs, `os_tick` repeats every 4 × ratio × 2^rate system cycles.
- R5: `bit_tick` fires only together with `os_tick`, on every 16th oversample tick. Exactly 16 oversample ticks fall between two bit ticks.
- R6: A write (`cfg_wr` high at a clock edge) reloads all counters. The first `os_tick` is then high in the cycle that starts 4 × ratio × 2^rate edges after the write edge, counting the write edge as the first. The first `bit_tick` comes 16 times as far out. In the cycle after the write, neither tick is high.
- R7: Both ticks are single-cycle pulses. Neither is ever high in two consecutive cycles.
- R8: `bit_div` changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pre_sel | input | 2 | Prescale select written on `cfg_wr` |
| cfg_rate | input | 3 | Rate select (power-of-two exponent) written on `cfg_wr` |
| os_tick | output | 1 | 16x oversample tick, one cycle wide |
| bit_tick | output | 1 | Per-bit tick, one cycle wide |
| bit_div | output | 15 | Current per-bit divisor in base-clock cycles |

## Verification
A wrong prescale decode or a wrong shift shows at once in `bit_div`, in the cycle after the write. It also shows in the spacing of `os_tick` within one oversample period, at most about 6,700 cycles. A restart fault leaves a stale phase, which moves the first tick away from its exact cycle after a write. A fault in the divide-by-16 stage shows only at the first bit tick, 16 oversample periods out, as a wrong count of oversample ticks per bit. The sweep covers every one of the 32 settings for oversample timing, and the low rate settings for bit timing.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int PRE_SEL_W  = 2;
  localparam int RATE_W     = 3;
  localparam int BASE_DIV   = 4;
  localparam int OS_FACTOR  = 16;
  localparam int PRE_MAX    = 13;
  localparam int OS_LEN_MAX = PRE_MAX << ((1 << RATE_W) - 1);
  localparam int OS_W       = $clog2(OS_LEN_MAX + 1);
  localparam int DIV_W      = $clog2(OS_LEN_MAX * OS_FACTOR + 1);

  typedef struct packed {
    logic [PRE_SEL_W-1:0] pre_sel;
    logic [RATE_W-1:0]    rate;
  } baud_cfg_t;

  // R2: non-binary prescale set, unknown codes use the largest ratio
  function automatic logic [OS_W-1:0] pre_ratio(logic [PRE_SEL_W-1:0] sel);
    case (sel)
      2'd0:    return OS_W'(1);
      2'd1:    return OS_W'(3);
      2'd2:    return OS_W'(4);
      default: return OS_W'(PRE_MAX);
    endcase
  endfunction

  // base-clock cycles per oversample tick
  function automatic logic [OS_W-1:0] os_len(baud_cfg_t c);
    return pre_ratio(c.pre_sel) << c.rate;
  endfunction

  // base-clock cycles per bit (R3)
  function automatic logic [DIV_W-1:0] bit_len(baud_cfg_t c);
    return DIV_W'(os_len(c)) * DIV_W'(OS_FACTOR);
  endfunction
endpackage

// File: rtl/base_enable.sv
module base_enable #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic en
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart)             cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign en = (cnt == CW'(DIV - 1));

  // R7: the base enable is a lone pulse
  p_en_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !en);
endmodule

// File: rtl/os_divider.sv
module os_divider
  import baud_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            en,
  input  logic [OS_W-1:0] len,
  output logic            os_tick
);
  logic [OS_W-1:0] cnt;
  logic            at_last;

  assign at_last = (cnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (en)      cnt <= at_last ? '0 : cnt + 1'b1;
  end

  assign os_tick = en && at_last;

  // R4: the count never passes the programmed length
  p_cnt_below_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);
  // R7
  p_os_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);
endmodule

// File: rtl/bit_divider.sv
module bit_divider #(
  parameter int FACTOR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic os_tick,
  output logic bit_tick
);
  localparam int CW = $clog2(FACTOR);
  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == CW'(FACTOR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (os_tick) cnt <= at_last ? '0 : cnt + 1'b1;
  end

  assign bit_tick = os_tick && at_last;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [PRE_SEL_W-1:0] cfg_pre_sel,
  input  logic [RATE_W-1:0]    cfg_rate,
  output logic                 os_tick,
  output logic                 bit_tick,
  output logic [DIV_W-1:0]     bit_div
);
  baud_cfg_t       cfg_q;
  logic            base_en;
  logic [OS_W-1:0] os_length;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= '{pre_sel: cfg_pre_sel, rate: cfg_rate};
  end

  assign os_length = os_len(cfg_q);
  assign bit_div   = bit_len(cfg_q);

  base_enable #(.DIV(BASE_DIV)) u_base (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .en(base_en));

  os_divider u_os (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .en(base_en),
    .len(os_length), .os_tick(os_tick));

  bit_divider #(.FACTOR(OS_FACTOR)) u_bit (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .os_tick(os_tick),
    .bit_tick(bit_tick));

  // R5: a bit tick always lands on an oversample tick
  p_bit_on_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  // R6: a write clears the phase, so no tick in the following cycle
  p_quiet_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !os_tick && !bit_tick);
  // R8: the divisor holds between writes
  p_div_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(bit_div));
  // R7
  p_bit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_pre_sel = '0;
  logic [2:0]  cfg_rate = '0;
  logic        os_tick, bit_tick;
  logic [14:0] bit_div;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;  // 125 MHz

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pre_sel(cfg_pre_sel),
    .cfg_rate(cfg_rate), .os_tick(os_tick), .bit_tick(bit_tick),
    .bit_div(bit_div));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input int sel);
    int r[4] = '{1, 3, 4, 13};
    return r[sel];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Write a setting, then time the ticks from the write edge.
  task automatic run_cfg(input int pre, input int rate, input bit do_bit);
    int len, n, os_first, os_second, bit_first, bit_second, os_between, pulse_prev;
    bit dbl;
    len = ratio_of(pre) << rate;
    @(negedge clk);
    cfg_pre_sel = 2'(pre); cfg_rate = 3'(rate); cfg_wr = 1'b1;
    n = 0; os_first = -1; os_second = -1; bit_first = -1; bit_second = -1;
    os_between = 0; pulse_prev = 0; dbl = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        cfg_wr = 1'b0;
        check(bit_div == 15'(len * 16), "R3 divisor", bit_div, len * 16);
        check(!os_tick && !bit_tick, "R6 quiet after write", os_tick, 0);
      end
      if (os_tick && pulse_prev != 0) dbl = 1;
      pulse_prev = os_tick;
      if (os_tick) begin
        if (os_first < 0) os_first = n;
        else if (os_second < 0) os_second = n;
        if (bit_first >= 0 && bit_second < 0) os_between++;
      end
      if (bit_tick) begin
        if (!os_tick) dbl = 1;
        if (bit_first < 0) bit_first = n;
        else if (bit_second < 0) bit_second = n;
      end
      if (!do_bit && os_second > 0) break;
      if (do_bit && bit_second > 0) break;
    end
    check(os_first == 4 * len, "R6 first os tick", os_first, 4 * len);
    check(os_second - os_first == 4 * len, "R4 os period", os_second - os_first, 4 * len);
    check(!dbl, "R7 single-cycle pulses", dbl, 0);
    if (do_bit) begin
      check(bit_first == 64 * len, "R6 first bit tick", bit_first, 64 * len);
      check(bit_second - bit_first == 64 * len, "R5 bit period",
            bit_second - bit_first, 64 * len);
      check(os_between == 16, "R5 os ticks per bit", os_between, 16);
    end
    // R8: no write since, divisor unchanged
    check(bit_div == 15'(len * 16), "R8 divisor held", bit_div, len * 16);
  endtask

  initial begin
    int n, os_first, bit_first;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bit_div == 15'd16, "R1 reset divisor", bit_div, 16);
    check(!os_tick && !bit_tick, "R1 ticks idle in reset", os_tick, 0);
    rst_n = 1'b1;
    n = 0; os_first = -1; bit_first = -1;
    while (n < 200 && bit_first < 0) begin
      @(negedge clk);
      n++;
      if (os_tick && os_first < 0) os_first = n;
      if (bit_tick && bit_first < 0) bit_first = n;
    end
    check(os_first == 3, "R1 first os tick after reset", os_first, 3);
    check(bit_first == 63, "R1 first bit tick after reset", bit_first, 63);

    // R2/R4/R6: every prescale and rate setting, oversample timing
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 8; r++)
        run_cfg(p, r, 1'b0);
    // R2/R5: bit timing at low rates for every prescale code
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 2; r++)
        run_cfg(p, r, 1'b1);
    // R6: rewrite mid-period, same then different setting
    run_cfg(3, 0, 1'b0);
    repeat (7) @(negedge clk);
    run_cfg(3, 0, 1'b1);
    run_cfg(1, 2, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule